// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves conditional branches for a simple 32-bit processor pipeline. Each cycle that `in_valid` is high, it reads a branch instruction word, the current program counter, the flag vector, the word that follows the instruction and the value of a register chosen elsewhere. From these it decides whether the branch is taken and what the next program counter is. It also reports whether the following word belongs to the branch, so the fetch logic can skip it.

A one-hot (or multi-hot) selector field in the instruction picks which flags are tested. The branch is taken when any selected flag is set. An empty selector branches unconditionally, and a selector with the reserved lowest bit set never branches. One instruction bit picks an absolute target or a PC-relative one. Another picks whether the target or offset comes from the register value or from the following word. A relative target is the branch's own address plus the offset, minus one. The result is registered and appears one cycle after the request.

Top module: `branch_resolve`

## Requirements
- R1: The selector is instruction bits [20:13]. Selector bit k (instruction bit 13+k) tests flag bit k, for k = 1..7. Flag bits are: 1 carry, 2 divide-by-zero, 3 not-equal, 4 equal, 5 greater-than, 6 less-than, 7 overflow. With selector bit 0 clear and the selector non-zero, the branch is taken exactly when some selected flag is set.
- R2: An all-zero selector makes the branch taken whatever the flags hold.
- R3: When selector bit 0 (instruction bit 13) is set, the branch is not taken, whatever the other selector bits and the flags hold.
- R4: Instruction bit 24 picks the operand source: 1 uses `reg_val`, 0 uses `ext_word`. `out_use_ext` equals the inverse of bit 24, whether or not the branch is taken.
- R5: Instruction bit 23 set means absolute: a taken branch gives next PC equal to the operand.
- R6: Instruction bit 23 clear means relative: a taken branch gives next PC = PC + operand - 1, modulo 2^32. An offset of -1234 therefore moves the PC back by 1235.
- R7: A branch that is not taken gives next PC = PC + 1 in the register form and PC + 2 in the following-word form, modulo 2^32.
- R8: Results appear on the cycle after `in_valid` with `out_valid` high. `out_valid` is low on every other cycle, and the other outputs then hold their last values. Reset clears all outputs to zero.
- R9: Flag bit 0 never causes a branch to be taken.
- R10: Instruction bits outside 24, 23 and [20:13] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A branch request is present this cycle |
| insn | input | 32 | Branch instruction word |
| pc | input | 32 | Address of the branch instruction |
| flags | input | 8 | Status flag vector |
| ext_word | input | 32 | Word following the instruction |
| reg_val | input | 32 | Value of the source register |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 32 | Next program counter |
| out_use_ext | output | 1 | The following word is part of this branch |

## Verification
The hardest cases to reach are the boundaries of the selector: the reserved bit set together with a matching flag, and flag bit 0 as the only set flag. Random selectors seldom reach either one. The stimulus sets these cases on purpose, and also covers wrap-around at both ends of the address space (PC zero with a zero relative offset, and the last address with a fall-through). Each request fills the unused instruction bits with random values, so that any dependence on them shows up in the scoreboard.

// File: rtl/brc_pkg.sv
package brc_pkg;
   // operand source picked by one instruction bit
   typedef enum logic {
      SRC_WORD = 1'b0,
      SRC_REG  = 1'b1
   } brc_src_e;

   // target kind picked by one instruction bit
   typedef enum logic {
      TGT_REL = 1'b0,
      TGT_ABS = 1'b1
   } brc_tgt_e;

   typedef struct packed {
      brc_src_e src;
      brc_tgt_e tgt;
   } brc_ctl_t;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval #(
   parameter int SEL_W   = 8,
   parameter bit RSV_LSB = 1'b1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [SEL_W-1:0] flags,
   output logic             take
);
   logic [SEL_W-1:0] hit_vec;
   logic             any_hit;
   logic             empty_sel;
   logic             blocked;

   genvar g;
   generate
      for (g = 1; g < SEL_W; g++) begin : g_match
         assign hit_vec[g] = sel[g] & flags[g];
      end
      if (RSV_LSB) begin : g_rsv
         logic unused_flag0;
         assign unused_flag0 = flags[0];
         assign hit_vec[0]   = 1'b0;
         assign blocked      = sel[0];
      end else begin : g_norsv
         assign hit_vec[0] = sel[0] & flags[0];
         assign blocked    = 1'b0;
      end
   endgenerate

   assign any_hit   = |hit_vec;
   assign empty_sel = (sel == '0);
   assign take      = !blocked && (empty_sel || any_hit);
endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
   parameter int PC_W        = 32,
   parameter int OFFSET_BIAS = 1
) (
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] operand,
   input  logic            is_abs,
   input  logic            two_word,
   output logic [PC_W-1:0] target,
   output logic [PC_W-1:0] fallthru
);
   localparam logic [PC_W-1:0] STEP_ONE = PC_W'(1);
   localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2);

   logic [PC_W-1:0] rel_tgt;

   generate
      if (OFFSET_BIAS == 0) begin : g_nobias
         assign rel_tgt = pc + operand;
      end else begin : g_bias
         localparam logic [PC_W-1:0] BIAS_V = PC_W'(OFFSET_BIAS);
         assign rel_tgt = pc + operand - BIAS_V;
      end
   endgenerate

   assign target   = is_abs ? operand : rel_tgt;
   assign fallthru = pc + (two_word ? STEP_TWO : STEP_ONE);
endmodule

// File: rtl/brc_out_stage.sv
module brc_out_stage #(
   parameter int W         = 34,
   parameter bit REGISTERD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_data,
   output logic         out_vld,
   output logic [W-1:0] out_data
);
   generate
      if (REGISTERD) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_vld  <= 1'b0;
               out_data <= '0;
            end else begin
               out_vld <= in_vld;
               if (in_vld) out_data <= in_data;
            end
         end
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign out_vld  = in_vld;
         assign out_data = in_data;
      end
   endgenerate
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
   import brc_pkg::*;
#(
   parameter int INSN_W      = 32,
   parameter int PC_W        = 32,
   parameter int SEL_W       = 8,
   parameter int SEL_LO      = 13,
   parameter int MODE_BIT    = 23,
   parameter int SRC_BIT     = 24,
   parameter int OFFSET_BIAS = 1,
   parameter bit RSV_LSB     = 1'b1,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] insn,
   input  logic [PC_W-1:0]   pc,
   input  logic [SEL_W-1:0]  flags,
   input  logic [PC_W-1:0]   ext_word,
   input  logic [PC_W-1:0]   reg_val,
   output logic              out_valid,
   output logic              out_taken,
   output logic [PC_W-1:0]   out_next_pc,
   output logic              out_use_ext
);
   localparam int SEL_HI = SEL_LO + SEL_W - 1;
   localparam int PAY_W  = PC_W + 2;

   generate
      if (SEL_HI >= INSN_W) begin : g_chk_sel
         $error("selector field runs past the instruction word");
      end
      if (MODE_BIT >= INSN_W || SRC_BIT >= INSN_W) begin : g_chk_bits
         $error("control bit outside the instruction word");
      end
      if (MODE_BIT == SRC_BIT) begin : g_chk_same
         $error("mode and source bits must differ");
      end
      if ((MODE_BIT >= SEL_LO && MODE_BIT <= SEL_HI) ||
          (SRC_BIT >= SEL_LO && SRC_BIT <= SEL_HI)) begin : g_chk_ovl
         $error("control bit overlaps the selector field");
      end
      if (PC_W < 2 || SEL_W < 2) begin : g_chk_w
         $error("widths too small");
      end
   endgenerate

   brc_ctl_t         ctl;
   logic [SEL_W-1:0] sel;
   logic [PC_W-1:0]  operand;
   logic [PC_W-1:0]  target;
   logic [PC_W-1:0]  fallthru;
   logic             take;
   logic             two_word;
   logic [PC_W-1:0]  next_pc;
   logic [PAY_W-1:0] pay_in;
   logic [PAY_W-1:0] pay_out;
   logic             unused_insn;

   // bits outside the decoded fields are don't-care
   assign unused_insn = ^insn;

   assign ctl.src  = brc_src_e'(insn[SRC_BIT]);
   assign ctl.tgt  = brc_tgt_e'(insn[MODE_BIT]);
   assign sel      = insn[SEL_LO +: SEL_W];
   assign two_word = (ctl.src == SRC_WORD);
   assign operand  = (ctl.src == SRC_REG) ? reg_val : ext_word;

   brc_cond_eval #(
      .SEL_W   (SEL_W),
      .RSV_LSB (RSV_LSB)
   ) u_cond (
      .sel   (sel),
      .flags (flags),
      .take  (take)
   );

   brc_target_calc #(
      .PC_W        (PC_W),
      .OFFSET_BIAS (OFFSET_BIAS)
   ) u_tgt (
      .pc       (pc),
      .operand  (operand),
      .is_abs   (ctl.tgt == TGT_ABS),
      .two_word (two_word),
      .target   (target),
      .fallthru (fallthru)
   );

   assign next_pc = take ? target : fallthru;
   assign pay_in  = {take, two_word, next_pc};

   brc_out_stage #(
      .W         (PAY_W),
      .REGISTERD (OUT_REG)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_valid),
      .in_data  (pay_in),
      .out_vld  (out_valid),
      .out_data (pay_out)
   );

   assign out_taken   = pay_out[PAY_W-1];
   assign out_use_ext = pay_out[PAY_W-2];
   assign out_next_pc = pay_out[PC_W-1:0];
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
   parameter int INSN_W      = 32,
   parameter int PC_W        = 32,
   parameter int SEL_W       = 8,
   parameter int SEL_LO      = 13,
   parameter int MODE_BIT    = 23,
   parameter int SRC_BIT     = 24,
   parameter int OFFSET_BIAS = 1,
   parameter bit OUT_REG     = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [INSN_W-1:0] insn,
   input logic [PC_W-1:0]   pc,
   input logic [SEL_W-1:0]  flags,
   input logic [PC_W-1:0]   ext_word,
   input logic [PC_W-1:0]   reg_val,
   input logic              out_valid,
   input logic              out_taken,
   input logic [PC_W-1:0]   out_next_pc,
   input logic              out_use_ext
);
   localparam logic [PC_W-1:0] BIAS_V = PC_W'(OFFSET_BIAS);

   logic [SEL_W-1:0] sel;
   logic [SEL_W-1:0] hits;
   logic [PC_W-1:0]  opnd;
   assign sel  = insn[SEL_LO +: SEL_W];
   assign hits = sel & flags & {{(SEL_W-1){1'b1}}, 1'b0};
   assign opnd = insn[SRC_BIT] ? reg_val : ext_word;

   generate
      if (OUT_REG) begin : g_seq
         p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));
         p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> $stable(out_next_pc) && $stable(out_taken));
         p_ext_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_use_ext == !$past(insn[SRC_BIT]));
         p_rsv_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && $past(sel[0]) |-> !out_taken);
         p_uncond_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && $past(sel == '0) |-> out_taken);
         p_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !$past(sel[0]) && $past(hits != '0) |-> out_taken);
         p_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && $past(sel != '0) && $past(hits == '0) |-> !out_taken);
         p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !out_taken |->
               out_next_pc == $past(pc) + (out_use_ext ? PC_W'(2) : PC_W'(1)));
         p_abs_r5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && out_taken && $past(insn[MODE_BIT]) |->
               out_next_pc == $past(opnd));
         p_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && out_taken && !$past(insn[MODE_BIT]) |->
               out_next_pc == $past(pc) + $past(opnd) - BIAS_V);
      end else begin : g_comb
         p_ext_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> out_use_ext == !insn[SRC_BIT]);
         p_rsv_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && sel[0] |-> !out_taken);
         p_uncond_r2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && sel == '0 |-> out_taken);
         p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
      end
   endgenerate
endmodule

bind branch_resolve branch_resolve_chk #(
   .INSN_W      (INSN_W),
   .PC_W        (PC_W),
   .SEL_W       (SEL_W),
   .SEL_LO      (SEL_LO),
   .MODE_BIT    (MODE_BIT),
   .SRC_BIT     (SRC_BIT),
   .OFFSET_BIAS (OFFSET_BIAS),
   .OUT_REG     (OUT_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .insn        (insn),
   .pc          (pc),
   .flags       (flags),
   .ext_word    (ext_word),
   .reg_val     (reg_val),
   .out_valid   (out_valid),
   .out_taken   (out_taken),
   .out_next_pc (out_next_pc),
   .out_use_ext (out_use_ext)
);

// File: tb/tb_branch_resolve.sv
module tb_branch_resolve;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [31:0] pc = '0;
   logic [7:0]  flags = '0;
   logic [31:0] ext_word = '0;
   logic [31:0] reg_val = '0;
   logic        out_valid;
   logic        out_taken;
   logic [31:0] out_next_pc;
   logic        out_use_ext;

   always #4 clk = ~clk;

   branch_resolve dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .pc(pc),
      .flags(flags), .ext_word(ext_word), .reg_val(reg_val),
      .out_valid(out_valid), .out_taken(out_taken),
      .out_next_pc(out_next_pc), .out_use_ext(out_use_ext)
   );

   typedef struct {
      string       tag;
      logic        taken;
      logic        ext;
      logic [31:0] nxt;
   } exp_t;

   exp_t        sbq[$];
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 0;
   logic [31:0] last_nxt = '0;

   // expected behaviour written from the requirements
   function automatic exp_t model(bit regsrc, bit absm, logic [7:0] sel,
                                  logic [7:0] fl, logic [31:0] pcv,
                                  logic [31:0] extv, logic [31:0] regv);
      exp_t e;
      logic [31:0] opnd;
      opnd = regsrc ? regv : extv;
      if (sel[0])          e.taken = 1'b0;   // R3
      else if (sel == 0)   e.taken = 1'b1;   // R2
      else                 e.taken = ((sel & fl & 8'hFE) != 0); // R1 R9
      e.ext = !regsrc;                       // R4
      if (e.taken) e.nxt = absm ? opnd : pcv + opnd - 32'd1;     // R5 R6
      else         e.nxt = pcv + (regsrc ? 32'd1 : 32'd2);       // R7
      return e;
   endfunction

   task automatic send(string tag, bit regsrc, bit absm, logic [7:0] sel,
                       logic [7:0] fl, logic [31:0] pcv, logic [31:0] extv,
                       logic [31:0] regv);
      logic [31:0] w;
      exp_t e;
      w = $urandom;            // junk in undecoded bits, R10
      w[24] = regsrc;
      w[23] = absm;
      w[20:13] = sel;
      @(negedge clk);
      insn = w; pc = pcv; flags = fl; ext_word = extv; reg_val = regv;
      in_valid = 1'b1;
      e = model(regsrc, absm, sel, fl, pcv, extv, regv);
      e.tag = tag;
      sbq.push_back(e);
      last_nxt = e.nxt;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      insn = $urandom; pc = $urandom; flags = $urandom;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         n_run++;
         if (sbq.size() == 0) begin
            n_fail++;
            $display("FAIL R8 unexpected result: act valid=1 exp valid=0");
         end else begin
            exp_t e;
            e = sbq.pop_front();
            if (out_taken !== e.taken || out_next_pc !== e.nxt ||
                out_use_ext !== e.ext) begin
               n_fail++;
               $display("FAIL %s act taken=%0b next=%h ext=%0b exp taken=%0b next=%h ext=%0b",
                        e.tag, out_taken, out_next_pc, out_use_ext,
                        e.taken, e.nxt, e.ext);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog expired: act hung exp finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      n_run++;
      if (out_valid !== 1'b0 || out_taken !== 1'b0 || out_next_pc !== 32'h0 ||
          out_use_ext !== 1'b0) begin
         n_fail++;
         $display("FAIL R8 reset act v=%0b t=%0b n=%h e=%0b exp all zero",
                  out_valid, out_taken, out_next_pc, out_use_ext);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1 each flag alone, matched and unmatched
      for (int k = 1; k < 8; k++) begin
         send("R1", 1'b0, 1'b0, 8'(1 << k), 8'(1 << k), 32'd1000, 32'd40, 32'd7);
         send("R1", 1'b1, 1'b1, 8'(1 << k), 8'hFE & ~8'(1 << k), 32'd1000, 32'd40, 32'd7);
      end
      send("R1", 1'b1, 1'b1, 8'h30, 8'h20, 32'h100, 32'h0, 32'hABCD);
      // R2 unconditional
      send("R2", 1'b0, 1'b1, 8'h00, 8'h00, 32'h200, 32'h5555, 32'h0);
      // R3 reserved bit overrides a match and the empty case
      send("R3", 1'b0, 1'b1, 8'h11, 8'hFF, 32'h300, 32'h9, 32'h9);
      send("R3", 1'b1, 1'b0, 8'h01, 8'h00, 32'h300, 32'h9, 32'h9);
      // R9 flag bit 0 alone does not take
      send("R9", 1'b1, 1'b0, 8'hFE, 8'h01, 32'h400, 32'h0, 32'h50);
      // R4 register source ignores following word
      send("R4", 1'b1, 1'b1, 8'h00, 8'h00, 32'h10, 32'hDEAD0000, 32'h00001234);
      send("R4", 1'b0, 1'b1, 8'h00, 8'h00, 32'h10, 32'hDEAD0000, 32'h00001234);
      // R5 absolute
      send("R5", 1'b0, 1'b1, 8'h08, 8'h08, 32'h7000, 32'h00001234, 32'h1);
      // R6 relative -1234 from 5000 lands on 3765
      send("R6", 1'b0, 1'b0, 8'h00, 8'h00, 32'd5000, -32'sd1234, 32'h0);
      send("R6", 1'b1, 1'b0, 8'h00, 8'h00, 32'h0, 32'h0, 32'h0);
      // R7 fall-through with wrap
      send("R7", 1'b0, 1'b0, 8'h02, 8'h00, 32'hFFFFFFFF, 32'h10, 32'h10);
      send("R7", 1'b1, 1'b0, 8'h02, 8'h00, 32'hFFFFFFFF, 32'h10, 32'h10);
      // R8 idle gap then hold
      idle();
      repeat (3) @(negedge clk);
      n_run++;
      if (out_valid !== 1'b0 || out_next_pc !== last_nxt) begin
         n_fail++;
         $display("FAIL R8 hold act v=%0b n=%h exp v=0 n=%h",
                  out_valid, out_next_pc, last_nxt);
      end
      // R10 random traffic with junk fields, mixed with gaps
      for (int i = 0; i < 300; i++) begin
         logic [7:0] s;
         s = 8'($urandom) & (($urandom % 3 == 0) ? 8'h00 : 8'hFF);
         s[0] = ($urandom % 8 == 0);
         send("R10", 1'($urandom), 1'($urandom), s, 8'($urandom),
              $urandom, $urandom, $urandom);
         if (i % 17 == 0) idle();
      end
      idle();
      while (sbq.size() != 0) @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule